// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Registered Flags

This block is the arithmetic and logic stage of an accumulator-style datapath. It holds an 8-bit accumulator and an 8-bit flag register. Each cycle with `op_valid` high, it applies the operation picked by `op_sel` to the accumulator and the operand `opnd`. The incoming carry always comes from the stored carry flag. On the next clock edge the accumulator takes the result, except for compare. The flag register is updated under a rule that belongs to each operation.

The operation set has binary add and subtract, each with and without carry, and compare. It also has the three bitwise logic operations, two's-complement negate, one's-complement, and a decimal adjust step that turns a binary sum or difference of two packed-BCD bytes back into BCD. Two carry-only operations set or invert the carry. Values are brought into the accumulator through the logic operations: clear it with AND 0x00, then OR in the value.

Flag byte layout, from bit 7 down to bit 0: sign, zero, reserved (0), half-carry, reserved (0), parity/overflow, subtract, carry.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `acc_q` and `flags_q` are 0x00.
- R2: When `op_valid` is low, or `op_sel` is 13, 14 or 15, neither `acc_q` nor `flags_q` changes at the next edge.
- R3: `op_sel` 0 gives A+r and `op_sel` 1 gives A+r+C. Flags: S is bit 7 of the result and Z is set when the result is zero. H is the carry out of bit 3 and P/V is signed overflow. N=0, and C is the carry out of bit 7.
- R4: `op_sel` 2 gives A−r and `op_sel` 3 gives A−r−C. H is the borrow out of bit 3, P/V is signed overflow, N=1 and C is the borrow. A subtract-with-carry of A from itself gives 0x00 with C clear, or 0xFF with C set, and C keeps its value.
- R5: `op_sel` 4 sets every flag as `op_sel` 2 would, and leaves `acc_q` unchanged.
- R6: `op_sel` 5, 6 and 7 give A AND r, A OR r and A XOR r. S and Z follow the result, and P/V is set when the result has an even number of ones. H, N and C are 0.
- R7: `op_sel` 8 gives 0x00−A. Z is set only when A was 0x00, P/V only when A was 0x80, and C unless A was 0x00. N=1.
- R8: `op_sel` 9 inverts every bit of A and leaves `flags_q` unchanged.
- R9: `op_sel` 10, after an add of two packed-BCD bytes, gives the BCD sum modulo 100. C is set when the decimal sum exceeds 99, N is kept, S and Z follow the result, and P/V is its even parity (for example 0x16+0x26=0x3C becomes 0x42).
- R10: `op_sel` 10, after a subtract of two packed-BCD bytes (N=1), gives the BCD difference modulo 100. C is set when the subtrahend was larger (for example 0x42−0x06=0x3C becomes 0x36).
- R11: `op_sel` 11 sets C and `op_sel` 12 inverts C. Both leave the accumulator and every other flag unchanged.
- R12: Flag bits 5 and 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Apply `op_sel` this cycle |
| op_sel | input | 4 | Operation code (see requirements) |
| opnd | input | 8 | Second operand r |
| acc_q | output | 8 | Accumulator register |
| flags_q | output | 8 | Flag register: S Z 0 H 0 PV N C |

## Verification
The carry and half-carry flags feed back into later operations: add-with-carry, subtract-with-borrow and decimal adjust all read them. A wrong bit in the flag register may therefore not show on `flags_q` until a later operation gives a wrong accumulator value, often one operation later through the decimal adjust step. For that reason the bench keeps a running model of both registers and compares them after every single operation. It sweeps all pairs of two-digit BCD values through add-then-adjust and subtract-then-adjust, so that a wrong correction term or a wrong decimal carry shows in the very next cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int DW  = 8;
    localparam int NIB = 4;
    localparam int OPW = 4;

    // flag bit positions
    localparam int F_C  = 0;
    localparam int F_N  = 1;
    localparam int F_PV = 2;
    localparam int F_H  = 4;
    localparam int F_Z  = 6;
    localparam int F_S  = 7;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_NEG = 4'd8,
        OP_INV = 4'd9,
        OP_DEC = 4'd10,
        OP_STC = 4'd11,
        OP_TGC = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_kind_e;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] flg;
    } alu_regs_t;

    function automatic logic even_parity(input logic [DW-1:0] v);
        return ~(^v);
    endfunction

    function automatic logic [DW-1:0] build_flags(
        input logic [DW-1:0] res,
        input logic          h,
        input logic          pv,
        input logic          n,
        input logic          c
    );
        logic [DW-1:0] f;
        f       = '0;
        f[F_S]  = res[DW-1];
        f[F_Z]  = (res == '0);
        f[F_H]  = h;
        f[F_PV] = pv;
        f[F_N]  = n;
        f[F_C]  = c;
        return f;
    endfunction
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int W  = 8,
    parameter int HB = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         co,
    output logic         hc,
    output logic         ov
);
    logic [W:0]  full;
    logic [HB:0] part;

    always_comb begin
        if (sub) begin
            full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
            part = {1'b0, x[HB-1:0]} - {1'b0, y[HB-1:0]} - {{HB{1'b0}}, cin};
            ov   = (x[W-1] != y[W-1]) && (full[W-1] != x[W-1]);
        end else begin
            full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
            part = {1'b0, x[HB-1:0]} + {1'b0, y[HB-1:0]} + {{HB{1'b0}}, cin};
            ov   = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
        end
        res = full[W-1:0];
        co  = full[W];
        hc  = part[HB];
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_kind_e  kind,
    output logic [W-1:0] res
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            unique case (kind)
                LG_AND:  res[i] = a[i] & b[i];
                LG_OR:   res[i] = a[i] | b[i];
                LG_XOR:  res[i] = a[i] ^ b[i];
                default: res[i] = a[i] ^ b[i];
            endcase
        end
    end
endmodule

// File: rtl/acc_alu_bcdfix.sv
module acc_alu_bcdfix
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic          n_in,
    input  logic          h_in,
    input  logic          c_in,
    output logic [DW-1:0] res,
    output logic          h_out,
    output logic          c_out
);
    localparam logic [NIB-1:0] DIGIT_MAX = 4'd9;
    localparam logic [NIB-1:0] SIX       = 4'd6;
    localparam logic [DW-1:0]  BYTE_MAX  = 8'h99;

    logic          lo_over;
    logic          hi_over;
    logic [DW-1:0] corr;

    always_comb begin
        lo_over = a[NIB-1:0] > DIGIT_MAX;
        hi_over = a > BYTE_MAX;
        corr    = {(c_in | hi_over) ? SIX : '0, (h_in | lo_over) ? SIX : '0};
        c_out   = c_in | hi_over;
        res     = n_in ? (a - corr) : (a + corr);
        h_out   = n_in ? (h_in & (a[NIB-1:0] < SIX)) : lo_over;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [OPW-1:0] op_sel,
    input  logic [DW-1:0] opnd,
    output logic [DW-1:0] acc_q,
    output logic [DW-1:0] flags_q
);
    alu_regs_t st_q;
    alu_regs_t st_d;

    // arithmetic path
    logic [DW-1:0] as_x;
    logic [DW-1:0] as_y;
    logic          as_cin;
    logic          as_sub;
    logic [DW-1:0] as_res;
    logic          as_co;
    logic          as_hc;
    logic          as_ov;

    // logic path
    logic_kind_e   lg_kind;
    logic [DW-1:0] lg_res;

    // decimal path
    logic [DW-1:0] dc_res;
    logic          dc_h;
    logic          dc_c;

    alu_op_e op;
    assign op = alu_op_e'(op_sel);

    always_comb begin
        as_x   = st_q.acc;
        as_y   = opnd;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC: as_cin = st_q.flg[F_C];
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBC: begin
                as_sub = 1'b1;
                as_cin = st_q.flg[F_C];
            end
            OP_NEG: begin
                as_sub = 1'b1;
                as_x   = '0;
                as_y   = st_q.acc;
            end
            default: ;
        endcase
    end

    acc_alu_addsub #(.W(DW), .HB(NIB)) addsub_i (
        .x   (as_x),
        .y   (as_y),
        .cin (as_cin),
        .sub (as_sub),
        .res (as_res),
        .co  (as_co),
        .hc  (as_hc),
        .ov  (as_ov)
    );

    always_comb begin
        unique case (op)
            OP_AND:  lg_kind = LG_AND;
            OP_OR:   lg_kind = LG_OR;
            default: lg_kind = LG_XOR;
        endcase
    end

    acc_alu_logic #(.W(DW)) logic_i (
        .a    (st_q.acc),
        .b    (opnd),
        .kind (lg_kind),
        .res  (lg_res)
    );

    acc_alu_bcdfix bcdfix_i (
        .a     (st_q.acc),
        .n_in  (st_q.flg[F_N]),
        .h_in  (st_q.flg[F_H]),
        .c_in  (st_q.flg[F_C]),
        .res   (dc_res),
        .h_out (dc_h),
        .c_out (dc_c)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            unique case (op)
                OP_ADD, OP_ADC: begin
                    st_d.acc = as_res;
                    st_d.flg = build_flags(as_res, as_hc, as_ov, 1'b0, as_co);
                end
                OP_SUB, OP_SBC, OP_NEG: begin
                    st_d.acc = as_res;
                    st_d.flg = build_flags(as_res, as_hc, as_ov, 1'b1, as_co);
                end
                OP_CMP: begin
                    st_d.flg = build_flags(as_res, as_hc, as_ov, 1'b1, as_co);
                end
                OP_AND, OP_OR, OP_XOR: begin
                    st_d.acc = lg_res;
                    st_d.flg = build_flags(lg_res, 1'b0, even_parity(lg_res), 1'b0, 1'b0);
                end
                OP_INV: st_d.acc = ~st_q.acc;
                OP_DEC: begin
                    st_d.acc = dc_res;
                    st_d.flg = build_flags(dc_res, dc_h, even_parity(dc_res),
                                           st_q.flg[F_N], dc_c);
                end
                OP_STC: st_d.flg[F_C] = 1'b1;
                OP_TGC: st_d.flg[F_C] = ~st_q.flg[F_C];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_q   = st_q.acc;
    assign flags_q = st_q.flg;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           op_valid,
    input logic [OPW-1:0] op_sel,
    input logic [DW-1:0]  acc_q,
    input logic [DW-1:0]  flags_q
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_sel > 4'd12) |=> ($stable(acc_q) && $stable(flags_q)));

    // R5
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd4) |=> $stable(acc_q));

    // R6
    logic_clears_cn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel >= 4'd5 && op_sel <= 4'd7) |=> (flags_q[F_C] == 1'b0 && flags_q[F_N] == 1'b0));

    // R8
    invert_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd9) |=> (acc_q == ~$past(acc_q) && $stable(flags_q)));

    // R11
    set_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd11) |=> (flags_q[F_C] && flags_q[7:1] == $past(flags_q[7:1]) && $stable(acc_q)));

    // R11
    flip_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd12) |=> (flags_q[F_C] != $past(flags_q[F_C]) && flags_q[7:1] == $past(flags_q[7:1])));

    // R12
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (flags_q[5] == 1'b0 && flags_q[3] == 1'b0));
endmodule

bind acc_alu acc_alu_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .acc_q    (acc_q),
    .flags_q  (flags_q)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_sel = 4'd0;
    logic [7:0] opnd = 8'd0;
    logic [7:0] acc_q;
    logic [7:0] flags_q;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    logic [7:0] exp_a = 8'd0;
    logic [7:0] exp_f = 8'd0;
    logic [7:0] daa_a;
    logic       daa_c;

    always #2 clk = ~clk;

    acc_alu dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_sel   (op_sel),
        .opnd     (opnd),
        .acc_q    (acc_q),
        .flags_q  (flags_q)
    );

    function automatic logic [7:0] mkf(input logic [7:0] r, input logic h, input logic pv,
                                       input logic n, input logic c);
        int ones;
        ones = 0;
        for (int i = 0; i < 8; i++) ones += r[i];
        return {r[7], (r == 8'd0), 1'b0, h, 1'b0, pv, n, c};
    endfunction

    function automatic logic par_even(input logic [7:0] r);
        int ones;
        ones = 0;
        for (int i = 0; i < 8; i++) ones += r[i];
        return (ones % 2) == 0;
    endfunction

    function automatic int sgn(input logic [7:0] v);
        return (v > 127) ? int'(v) - 256 : int'(v);
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic string req_of(input logic [3:0] op, input logic v);
        if (!v || op > 4'd12) return "R2";
        case (op)
            4'd0, 4'd1: return "R3";
            4'd2, 4'd3: return "R4";
            4'd4:       return "R5";
            4'd5, 4'd6, 4'd7: return "R6";
            4'd8:       return "R7";
            4'd9:       return "R8";
            4'd10:      return "R9/R10";
            default:    return "R11";
        endcase
    endfunction

    // reference model, written from the requirements
    task automatic model(input logic [3:0] op, input logic [7:0] b);
        int a, bb, cc, s, ss;
        logic [7:0] r;
        a  = int'(exp_a);
        bb = int'(b);
        cc = exp_f[0];
        case (op)
            4'd0, 4'd1: begin
                if (op == 4'd0) cc = 0;
                s  = a + bb + cc;
                ss = sgn(exp_a) + sgn(b) + cc;
                r  = 8'(s);
                exp_a = r;
                exp_f = mkf(r, ((a % 16) + (bb % 16) + cc) > 15, (ss > 127) || (ss < -128), 1'b0, s > 255);
            end
            4'd2, 4'd3, 4'd4, 4'd8: begin
                logic [7:0] xa, yb;
                if (op == 4'd2 || op == 4'd4 || op == 4'd8) cc = 0;
                xa = exp_a;
                yb = b;
                if (op == 4'd8) begin
                    xa = 8'd0;
                    yb = exp_a;
                end
                s  = int'(xa) - int'(yb) - cc;
                ss = sgn(xa) - sgn(yb) - cc;
                r  = 8'(s + 512);
                if (op != 4'd4) exp_a = r;
                exp_f = mkf(r, ((int'(xa) % 16) - (int'(yb) % 16) - cc) < 0,
                            (ss > 127) || (ss < -128), 1'b1, s < 0);
            end
            4'd5, 4'd6, 4'd7: begin
                r = (op == 4'd5) ? (exp_a & b) : (op == 4'd6) ? (exp_a | b) : (exp_a ^ b);
                exp_a = r;
                exp_f = mkf(r, 1'b0, par_even(r), 1'b0, 1'b0);
            end
            4'd9: exp_a = ~exp_a;
            4'd10: begin
                exp_a = daa_a;
                exp_f = mkf(daa_a, 1'b0, par_even(daa_a), exp_f[1], daa_c);
            end
            4'd11: exp_f[0] = 1'b1;
            4'd12: exp_f[0] = ~exp_f[0];
            default: ;
        endcase
    endtask

    task automatic do_op(input logic [3:0] op, input logic [7:0] b, input logic v);
        logic [7:0] mask;
        string      tag;
        @(negedge clk);
        op_valid = v;
        op_sel   = op;
        opnd     = b;
        if (v) model(op, b);
        mask = (v && op == 4'd10) ? 8'hEF : 8'hFF;
        tag  = req_of(op, v);
        @(posedge clk);
        #1;
        n_checks++;
        if (acc_q !== exp_a || ((flags_q ^ exp_f) & mask) !== 8'd0) begin
            n_errors++;
            $display("FAIL %s op=%0d b=%02h: acc=%02h flags=%02h expected acc=%02h flags=%02h",
                     tag, op, b, acc_q, flags_q, exp_a, exp_f);
        end
        // half-carry after decimal adjust is not predicted; follow the port value
        if (v && op == 4'd10) exp_f[4] = flags_q[4];
    endtask

    task automatic load(input logic [7:0] val);
        do_op(4'd5, 8'h00, 1'b1);
        do_op(4'd6, val, 1'b1);
    endtask

    task automatic expect_val(input string tag, input logic [7:0] got, input logic [7:0] want);
        n_checks++;
        if (got !== want) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, got, want);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: state in reset
        expect_val("R1 acc", acc_q, 8'h00);
        expect_val("R1 flags", flags_q, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        expect_val("R1 acc after release", acc_q, 8'h00);

        // R9 worked example
        load(8'h16);
        do_op(4'd0, 8'h26, 1'b1);
        expect_val("R9 binary sum", acc_q, 8'h3C);
        daa_a = 8'h42; daa_c = 1'b0;
        do_op(4'd10, 8'h00, 1'b1);
        expect_val("R9 adjusted", acc_q, 8'h42);

        // R10 worked example
        load(8'h42);
        do_op(4'd2, 8'h06, 1'b1);
        daa_a = 8'h36; daa_c = 1'b0;
        do_op(4'd10, 8'h00, 1'b1);
        expect_val("R10 adjusted", acc_q, 8'h36);

        // R4 subtract-with-borrow of A from itself
        load(8'h5A);
        do_op(4'd3, 8'h5A, 1'b1);
        expect_val("R4 sbc self no carry", acc_q, 8'h00);
        do_op(4'd11, 8'h00, 1'b1);
        do_op(4'd3, 8'h00, 1'b1);
        expect_val("R4 sbc self carry", acc_q, 8'hFF);
        expect_val("R4 carry kept", {7'd0, flags_q[0]}, 8'h01);
        do_op(4'd3, 8'hFF, 1'b1);
        expect_val("R4 sbc self carry again", acc_q, 8'hFF);

        // R7 negate corners
        load(8'h00);
        do_op(4'd8, 8'h00, 1'b1);
        expect_val("R7 neg zero flags ZC", {6'd0, flags_q[6], flags_q[0]}, 8'h02);
        load(8'h80);
        do_op(4'd8, 8'h00, 1'b1);
        expect_val("R7 neg 80 PV", {7'd0, flags_q[2]}, 8'h01);
        expect_val("R7 neg 80 result", acc_q, 8'h80);

        // R8 complement
        load(8'hD5);
        do_op(4'd9, 8'h00, 1'b1);
        expect_val("R8 complement", acc_q, 8'h2A);

        // R11 carry operations
        do_op(4'd12, 8'h00, 1'b1);
        do_op(4'd12, 8'h00, 1'b1);
        do_op(4'd11, 8'h00, 1'b1);
        do_op(4'd11, 8'h00, 1'b1);

        // R2 idle and unused codes
        do_op(4'd0, 8'h33, 1'b0);
        do_op(4'd13, 8'h33, 1'b1);
        do_op(4'd15, 8'hFF, 1'b1);

        // R9 exhaustive BCD sums
        for (int x = 0; x < 100; x++) begin
            for (int y = 0; y < 100; y++) begin
                load(to_bcd(x));
                do_op(4'd0, to_bcd(y), 1'b1);
                daa_a = to_bcd((x + y) % 100);
                daa_c = (x + y) > 99;
                do_op(4'd10, 8'h00, 1'b1);
            end
        end

        // R10 exhaustive BCD differences
        for (int x = 0; x < 100; x++) begin
            for (int y = 0; y < 100; y++) begin
                load(to_bcd(x));
                do_op(4'd2, to_bcd(y), 1'b1);
                daa_a = to_bcd((x - y + 100) % 100);
                daa_c = x < y;
                do_op(4'd10, 8'h00, 1'b1);
            end
        end

        // R3..R8, R11, R12: random operations against the model
        for (int i = 0; i < 6000; i++) begin
            logic [3:0] op;
            logic [7:0] b;
            logic       v;
            op = 4'($urandom_range(0, 15));
            if (op == 4'd10) op = 4'd1;
            b = 8'($urandom_range(0, 255));
            v = ($urandom_range(0, 7) != 0);
            do_op(op, b, v);
            if (i % 500 == 0) expect_val("R12 reserved bits", flags_q & 8'h28, 8'h00);
        end

        @(negedge clk);
        op_valid = 1'b0;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule